// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Bus Sequencer

This block is the host-side controller for a multi-channel, simultaneous-sampling converter that sits on a shared parallel bus. A one-cycle start request latches a 4-bit setup word. The block writes that word to the converter under chip-select and write strobes, then stops driving the bus. It next holds convert-start low for an acquisition window and raises it to begin the conversion. It waits for the converter's end-of-conversion flag to fall, and then pulls each channel's 16-bit result off the bus with one read-strobe low pulse per channel. Every captured word appears for one cycle on a valid/data output together with its channel number.

All analog timing limits are given as clock-cycle counts through parameters. These are the acquisition low time, the short convert-start pulse allowed in the free-running acquisition mode, the bus-quiet window before the conversion edge, the write and read strobe widths, and the end-of-conversion timeout. If the continuous input is high when a readout ends, the block waits a programmable gap and runs another conversion without rewriting the setup word.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, chip-select, write strobe, read strobe and convert-start are all high, the bus driver is off, and valid, busy and timeout are low.
- R2: A start accepted while idle latches the setup word and begins the write. For WR_LO_CYC cycles chip-select and write are low with the word driven on bus bits 3..0. Write then rises for one cycle while chip-select stays low and the word is still driven. After that the bus driver turns off.
- R3: When setup bit 0 is 0 (controlled acquisition), convert-start stays low for exactly the larger of ACQ_CYC and QUIET_CYC cycles before it rises.
- R4: When setup bit 0 is 1 (free-running acquisition), convert-start stays low for exactly the larger of PULSE_CYC and QUIET_CYC cycles before it rises.
- R5: While convert-start is low, and for at least QUIET_CYC cycles before each rising edge, chip-select, write and read stay high and the bus driver is off.
- R6: After convert-start rises the block holds the bus idle. The readout starts in the cycle after one in which end-of-conversion is sampled low following a high sample.
- R7: If end-of-conversion has not fallen within EOC_TIMEOUT cycles of the conversion edge, timeout is high for exactly one cycle, and then the block is idle.
- R8: The readout issues NCH read-strobe low pulses of RD_LO_CYC cycles each, separated by RD_HI_CYC high cycles. Chip-select stays low from the first pulse through the high phase after the last one, and then rises.
- R9: In the cycle after each read-strobe low phase ends, valid is high for one cycle. data carries the bus value sampled on the last low cycle, and chan carries the channel index, counting from 0.
- R10: If continuous is high on the last cycle of a readout, the block keeps the bus idle for interval+1 cycles and then begins the next acquisition with no new setup write. Otherwise it goes idle.
- R11: A start request while busy has no effect: exactly one setup write occurs per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| cont_i | input | 1 | Repeat conversions when high |
| interval_i | input | IW | Gap between repeated conversions, in cycles minus one |
| cfg_i | input | CFG_W | Setup word; bit 0 picks the acquisition mode |
| cs_n_o | output | 1 | Converter chip-select, active low |
| wr_n_o | output | 1 | Setup write strobe, active low |
| rd_n_o | output | 1 | Result read strobe, active low |
| convst_o | output | 1 | Convert-start; low acquires, rising edge converts |
| eoc_i | input | 1 | End-of-conversion flag from the converter |
| bus_o | output | CFG_W | Setup word driven on the low bus bits |
| bus_oe_o | output | 1 | Enable for the host's low-bit bus driver |
| bus_i | input | DW | Converter result bus |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | DW | Captured result word |
| chan_o | output | CHW | Channel index of the captured word |
| busy_o | output | 1 | Sequence in progress |
| timeout_o | output | 1 | End-of-conversion timeout pulse |

## Verification
A cycle-level reference model runs beside the design and tries it with several kinds of traffic. Single conversions in both acquisition modes separate the two convert-start low lengths. A one-cycle end-of-conversion delay and a longer delay show whether the block waits for the falling edge rather than a level. A converter that never lowers its flag exercises the timeout path. Continuous runs with a nonzero gap and with a zero gap check the repeat interval and that the setup is not rewritten, and start pulses sent mid-sequence show that a busy block ignores them.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG,
        ST_REL,
        ST_ACQ,
        ST_CONV,
        ST_RDLO,
        ST_RDHI,
        ST_GAP,
        ST_ERR
    } seq_st_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_eoc_watch.sv
`timescale 1ns/1ps
module adc_eoc_watch #(
    parameter int unsigned EOC_TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic eoc_i,
    output logic fell_o,
    output logic late_o
);
    localparam int unsigned TW = $clog2(EOC_TIMEOUT + 1);

    typedef struct packed {
        logic          prev;
        logic [TW-1:0] tcnt;
    } watch_t;

    watch_t d, q;

    always_comb begin
        d      = q;
        d.prev = eoc_i;
        fell_o = arm_i && q.prev && !eoc_i;
        late_o = arm_i && !fell_o && (q.tcnt == TW'(EOC_TIMEOUT - 1));
        if (arm_i) begin
            d.tcnt = q.tcnt + 1'b1;
        end else begin
            d.tcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/adc_rd_capture.sv
`timescale 1ns/1ps
module adc_rd_capture #(
    parameter int unsigned DW  = 16,
    parameter int unsigned CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_i,
    input  logic [CHW-1:0] ch_i,
    input  logic [DW-1:0]  bus_i,
    output logic           valid_o,
    output logic [DW-1:0]  data_o,
    output logic [CHW-1:0] chan_o
);
    typedef struct packed {
        logic           valid;
        logic [DW-1:0]  data;
        logic [CHW-1:0] chan;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d       = q;
        d.valid = cap_i;
        if (cap_i) begin
            d.data = bus_i;
            d.chan = ch_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.valid;
    assign data_o  = q.data;
    assign chan_o  = q.chan;
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned CFG_W     = 4,
    parameter int unsigned IW        = 8,
    parameter int unsigned WR_LO_CYC = 4,
    parameter int unsigned ACQ_CYC   = 125,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned QUIET_CYC = 63,
    parameter int unsigned RD_LO_CYC = 4,
    parameter int unsigned RD_HI_CYC = 4,
    localparam int unsigned CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [IW-1:0]    interval_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             fell_i,
    input  logic             late_i,
    output seq_st_e          st_o,
    output logic [CHW-1:0]   ch_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             cap_o
);
    localparam int unsigned A0      = umax(ACQ_CYC, QUIET_CYC);
    localparam int unsigned A1      = umax(PULSE_CYC, QUIET_CYC);
    localparam int unsigned STRB    = umax(WR_LO_CYC, umax(RD_LO_CYC, RD_HI_CYC));
    localparam int unsigned CNT_MAX = umax(umax(A0, A1), umax(STRB, 2 ** IW));
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CW-1:0]    cnt;
        logic [CHW-1:0]   ch;
        logic [CFG_W-1:0] cfg;
    } fsm_t;

    fsm_t d, q;
    logic [CW-1:0] acq_len;

    always_comb begin
        d       = q;
        cap_o   = 1'b0;
        acq_len = q.cfg[0] ? CW'(A1) : CW'(A0);
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_CFG;
                    d.cfg = cfg_i;
                    d.cnt = '0;
                end
            end
            ST_CFG: begin
                if (q.cnt == CW'(WR_LO_CYC - 1)) begin
                    d.st  = ST_REL;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_REL: begin
                d.st  = ST_ACQ;
                d.cnt = '0;
            end
            ST_ACQ: begin
                if (q.cnt == acq_len - 1'b1) begin
                    d.st  = ST_CONV;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (fell_i) begin
                    d.st  = ST_RDLO;
                    d.ch  = '0;
                    d.cnt = '0;
                end else if (late_i) begin
                    d.st  = ST_ERR;
                end
            end
            ST_RDLO: begin
                if (q.cnt == CW'(RD_LO_CYC - 1)) begin
                    cap_o = 1'b1;
                    d.st  = ST_RDHI;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RDHI: begin
                if (q.cnt == CW'(RD_HI_CYC - 1)) begin
                    d.cnt = '0;
                    if (q.ch == CHW'(NCH - 1)) begin
                        d.st = cont_i ? ST_GAP : ST_IDLE;
                    end else begin
                        d.ch = q.ch + 1'b1;
                        d.st = ST_RDLO;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt >= CW'(interval_i)) begin
                    d.st  = ST_ACQ;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ERR: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, ch: '0, cfg: '0};
        end else begin
            q <= d;
        end
    end

    assign st_o  = q.st;
    assign ch_o  = q.ch;
    assign cfg_o = q.cfg;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned NCH         = 8,
    parameter int unsigned DW          = 16,
    parameter int unsigned CFG_W       = 4,
    parameter int unsigned IW          = 8,
    parameter int unsigned WR_LO_CYC   = 4,
    parameter int unsigned ACQ_CYC     = 125,
    parameter int unsigned PULSE_CYC   = 3,
    parameter int unsigned QUIET_CYC   = 63,
    parameter int unsigned RD_LO_CYC   = 4,
    parameter int unsigned RD_HI_CYC   = 4,
    parameter int unsigned EOC_TIMEOUT = 1000,
    localparam int unsigned CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [IW-1:0]    interval_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             cs_n_o,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic             convst_o,
    input  logic             eoc_i,
    output logic [CFG_W-1:0] bus_o,
    output logic             bus_oe_o,
    input  logic [DW-1:0]    bus_i,
    output logic             valid_o,
    output logic [DW-1:0]    data_o,
    output logic [CHW-1:0]   chan_o,
    output logic             busy_o,
    output logic             timeout_o
);
    localparam int unsigned MIN_LOW = umin(umax(ACQ_CYC, QUIET_CYC), umax(PULSE_CYC, QUIET_CYC));

    seq_st_e          st;
    logic [CHW-1:0]   ch;
    logic [CFG_W-1:0] cfg_q;
    logic             cap;
    logic             fell;
    logic             late;

    adc_seq_fsm #(
        .NCH(NCH), .CFG_W(CFG_W), .IW(IW), .WR_LO_CYC(WR_LO_CYC),
        .ACQ_CYC(ACQ_CYC), .PULSE_CYC(PULSE_CYC), .QUIET_CYC(QUIET_CYC),
        .RD_LO_CYC(RD_LO_CYC), .RD_HI_CYC(RD_HI_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .interval_i(interval_i), .cfg_i(cfg_i), .fell_i(fell), .late_i(late),
        .st_o(st), .ch_o(ch), .cfg_o(cfg_q), .cap_o(cap)
    );

    adc_eoc_watch #(
        .EOC_TIMEOUT(EOC_TIMEOUT)
    ) u_eoc (
        .clk(clk), .rst_n(rst_n), .arm_i(st == ST_CONV), .eoc_i(eoc_i),
        .fell_o(fell), .late_o(late)
    );

    adc_rd_capture #(
        .DW(DW), .CHW(CHW)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .ch_i(ch), .bus_i(bus_i),
        .valid_o(valid_o), .data_o(data_o), .chan_o(chan_o)
    );

    always_comb begin
        cs_n_o   = 1'b1;
        wr_n_o   = 1'b1;
        rd_n_o   = 1'b1;
        convst_o = 1'b1;
        bus_oe_o = 1'b0;
        case (st)
            ST_CFG: begin
                cs_n_o   = 1'b0;
                wr_n_o   = 1'b0;
                bus_oe_o = 1'b1;
            end
            ST_REL: begin
                cs_n_o   = 1'b0;
                bus_oe_o = 1'b1;
            end
            ST_ACQ:  convst_o = 1'b0;
            ST_RDLO: begin
                cs_n_o = 1'b0;
                rd_n_o = 1'b0;
            end
            ST_RDHI: cs_n_o = 1'b0;
            default: ;
        endcase
    end

    assign bus_o     = cfg_q;
    assign busy_o    = (st != ST_IDLE);
    assign timeout_o = (st == ST_ERR);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk #(
    parameter int unsigned QUIET_CYC = 63,
    parameter int unsigned MIN_LOW   = 63
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic wr_n_o,
    input logic rd_n_o,
    input logic convst_o,
    input logic bus_oe_o,
    input logic valid_o,
    input logic busy_o,
    input logic timeout_o
);
    localparam int unsigned SAT = 32'h4000_0000;

    int unsigned low_run;
    int unsigned quiet_run;
    logic        bus_active;

    assign bus_active = !cs_n_o || !wr_n_o || !rd_n_o || bus_oe_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= 0;
            quiet_run <= 0;
        end else begin
            low_run   <= convst_o ? 0 : ((low_run < SAT) ? low_run + 1 : low_run);
            quiet_run <= bus_active ? 0 : ((quiet_run < SAT) ? quiet_run + 1 : quiet_run);
        end
    end

    AST_ACQ_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !convst_o |-> (cs_n_o && wr_n_o && rd_n_o && !bus_oe_o)); // R5
    AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_o) |-> (quiet_run >= QUIET_CYC)); // R5
    AST_ACQ_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convst_o) |-> (low_run >= MIN_LOW)); // R3
    AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (!cs_n_o && bus_oe_o)); // R2
    AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (!cs_n_o && !bus_oe_o)); // R8
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (rd_n_o && $past(!rd_n_o))); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_TIMEOUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (!timeout_o && !busy_o)); // R7
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .QUIET_CYC(QUIET_CYC), .MIN_LOW(MIN_LOW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o),
    .convst_o(convst_o), .bus_oe_o(bus_oe_o), .valid_o(valid_o),
    .busy_o(busy_o), .timeout_o(timeout_o)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
    localparam int NCH = 4, DW = 16, CFG_W = 4, IW = 6;
    localparam int WR_LO = 2, ACQ = 20, PULSE = 3, QUIET = 12;
    localparam int RD_LO = 3, RD_HI = 2, TOUT = 40;
    localparam int CHW = 2;
    localparam int LEN_M0 = (ACQ > QUIET) ? ACQ : QUIET;
    localparam int LEN_M1 = (PULSE > QUIET) ? PULSE : QUIET;

    logic clk = 1'b0;
    logic rst_n;
    logic start_i = 1'b0, cont_i = 1'b0;
    logic [IW-1:0] interval_i = '0;
    logic [CFG_W-1:0] cfg_i = '0;
    logic cs_n_o, wr_n_o, rd_n_o, convst_o, bus_oe_o, valid_o, busy_o, timeout_o;
    logic [CFG_W-1:0] bus_o;
    logic [DW-1:0] bus_i, data_o;
    logic [CHW-1:0] chan_o;
    logic eoc;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(
        .NCH(NCH), .DW(DW), .CFG_W(CFG_W), .IW(IW), .WR_LO_CYC(WR_LO),
        .ACQ_CYC(ACQ), .PULSE_CYC(PULSE), .QUIET_CYC(QUIET), .RD_LO_CYC(RD_LO),
        .RD_HI_CYC(RD_HI), .EOC_TIMEOUT(TOUT)
    ) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .interval_i(interval_i), .cfg_i(cfg_i), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o),
        .rd_n_o(rd_n_o), .convst_o(convst_o), .eoc_i(eoc), .bus_o(bus_o),
        .bus_oe_o(bus_oe_o), .bus_i(bus_i), .valid_o(valid_o), .data_o(data_o),
        .chan_o(chan_o), .busy_o(busy_o), .timeout_o(timeout_o)
    );

    function automatic logic [15:0] pat(input int c, input int r);
        return 16'(c * 257) ^ 16'(r * 4369) ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // converter model
    int eoc_lat = 4;
    bit eoc_dead = 0;
    int conv_cnt, rd_cnt, busy_cnt;
    logic cv_prev, rd_prev;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc <= 1'b0; cv_prev <= 1'b1; rd_prev <= 1'b1;
            conv_cnt <= 0; rd_cnt <= 0; busy_cnt <= 0;
        end else begin
            cv_prev <= convst_o;
            rd_prev <= rd_n_o;
            if (!cv_prev && convst_o) begin
                conv_cnt <= conv_cnt + 1; rd_cnt <= 0; eoc <= 1'b1; busy_cnt <= eoc_lat;
            end else begin
                if (!rd_prev && rd_n_o) rd_cnt <= rd_cnt + 1;
                if (busy_cnt > 0) begin
                    busy_cnt <= busy_cnt - 1;
                    if (busy_cnt == 1 && !eoc_dead) eoc <= 1'b0;
                end
            end
        end
    end
    assign bus_i = (!cs_n_o && !rd_n_o) ? pat(conv_cnt, rd_cnt) : '0;

    // reference model
    logic e_cs, e_wr, e_rd, e_cv, e_oe, e_busy, e_to, e_valid;
    logic [DW-1:0] e_data;
    int e_chan;
    string e_tag;
    logic m_eoc_prev = 0, m_eoc_now = 0, m_start, m_cont;
    logic [CFG_W-1:0] m_cfg_in, m_cfg;
    int m_ival, m_conv = 0;

    task automatic set_exp(input logic cs, wr, rd, cv, oe, bz, to, input string tag);
        e_cs = cs; e_wr = wr; e_rd = rd; e_cv = cv; e_oe = oe; e_busy = bz; e_to = to; e_tag = tag;
    endtask

    task automatic tick;
        @(posedge clk);
        m_eoc_prev = m_eoc_now; m_eoc_now = eoc;
        m_start = start_i; m_cont = cont_i; m_cfg_in = cfg_i; m_ival = int'(interval_i);
        e_valid = 1'b0;
    endtask

    task automatic job;
        bit got;
        int tcnt, alen;
        string atag;
        for (int k = 0; k < WR_LO; k++) begin set_exp(0,0,1,1,1,1,0,"R2"); tick(); end
        set_exp(0,1,1,1,1,1,0,"R2"); tick();
        forever begin
            alen = m_cfg[0] ? LEN_M1 : LEN_M0;
            atag = m_cfg[0] ? "R4" : "R3";
            for (int k = 0; k < alen; k++) begin set_exp(1,1,1,0,0,1,0,atag); tick(); end
            m_conv++;
            got = 0; tcnt = 0;
            while (1) begin
                set_exp(1,1,1,1,0,1,0,"R6"); tick();
                if (m_eoc_prev && !m_eoc_now) begin got = 1; break; end
                tcnt++;
                if (tcnt == TOUT) break;
            end
            if (!got) begin set_exp(1,1,1,1,0,1,1,"R7"); tick(); return; end
            for (int ch = 0; ch < NCH; ch++) begin
                for (int k = 0; k < RD_LO; k++) begin set_exp(0,1,0,1,0,1,0,"R8"); tick(); end
                for (int k = 0; k < RD_HI; k++) begin
                    set_exp(0,1,1,1,0,1,0,"R8");
                    if (k == 0) begin e_valid = 1'b1; e_data = pat(m_conv, ch); e_chan = ch; end
                    tick();
                end
            end
            if (!m_cont) return;
            for (int k = 0; k <= m_ival; k++) begin set_exp(1,1,1,1,0,1,0,"R10"); tick(); end
        end
    endtask

    initial begin : model
        set_exp(1,1,1,1,0,0,0,"R1"); e_valid = 1'b0;
        @(posedge rst_n);
        forever begin
            set_exp(1,1,1,1,0,0,0,"R1");
            tick();
            if (m_start) begin m_cfg = m_cfg_in; job(); end
        end
    end

    // per-cycle comparison and bus observers
    int wr_rises = 0, quiet = 0, to_seen = 0;
    logic wr_last = 1'b1, cv_last = 1'b1;
    always @(negedge clk) begin
        chk(cs_n_o === e_cs, e_tag, "cs_n", cs_n_o, e_cs);
        chk(wr_n_o === e_wr, e_tag, "wr_n", wr_n_o, e_wr);
        chk(rd_n_o === e_rd, e_tag, "rd_n", rd_n_o, e_rd);
        chk(convst_o === e_cv, e_tag, "convst", convst_o, e_cv);
        chk(bus_oe_o === e_oe, e_tag, "bus_oe", bus_oe_o, e_oe);
        if (e_oe) chk(bus_o === m_cfg, "R2", "bus_o", bus_o, m_cfg);
        chk(busy_o === e_busy, e_tag, "busy", busy_o, e_busy);
        chk(timeout_o === e_to, "R7", "timeout", timeout_o, e_to);
        chk(valid_o === e_valid, "R9", "valid", valid_o, e_valid);
        if (e_valid) begin
            chk(data_o === e_data, "R9", "data", data_o, e_data);
            chk(int'(chan_o) == e_chan, "R9", "chan", chan_o, e_chan);
        end
        if (timeout_o) to_seen++;
        if (!wr_last && wr_n_o) wr_rises++;
        wr_last = wr_n_o;
        if (cv_last === 1'b0 && convst_o === 1'b1)
            chk(quiet >= QUIET, "R5", "quiet_cycles", quiet, QUIET);
        cv_last = convst_o;
        if (!cs_n_o || !wr_n_o || !rd_n_o || bus_oe_o) quiet = 0; else quiet++;
    end

    task automatic pulse_start(input logic [CFG_W-1:0] c);
        @(negedge clk); cfg_i = c; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int w0, c0, t0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: controlled acquisition, slow end of conversion
        eoc_lat = 6;
        pulse_start(4'b1010);
        wait_idle();

        // R4, R6: free-running acquisition, fastest end of conversion
        eoc_lat = 1;
        pulse_start(4'b0101);
        wait_idle();

        // R11: start pulses while busy are ignored
        eoc_lat = 3;
        w0 = wr_rises;
        pulse_start(4'b0000);
        repeat (5) @(negedge clk);
        pulse_start(4'b1111);
        repeat (30) @(negedge clk);
        pulse_start(4'b0111);
        wait_idle();
        chk(wr_rises - w0 == 1, "R11", "setup_writes", wr_rises - w0, 1);

        // R10: continuous with a gap, three conversions, one setup write
        w0 = wr_rises; c0 = conv_cnt;
        cont_i = 1'b1; interval_i = 6'd5; eoc_lat = 2;
        pulse_start(4'b0001);
        for (int i = 0; i < 5000 && conv_cnt < c0 + 3; i++) @(negedge clk);
        cont_i = 1'b0;
        wait_idle();
        chk(conv_cnt - c0 == 3, "R10", "conversions", conv_cnt - c0, 3);
        chk(wr_rises - w0 == 1, "R10", "setup_writes", wr_rises - w0, 1);

        // R10: continuous with zero gap, mode 0
        c0 = conv_cnt;
        cont_i = 1'b1; interval_i = 6'd0; eoc_lat = 4;
        pulse_start(4'b0100);
        for (int i = 0; i < 5000 && conv_cnt < c0 + 2; i++) @(negedge clk);
        cont_i = 1'b0;
        wait_idle();
        chk(conv_cnt - c0 == 2, "R10", "conversions_zero_gap", conv_cnt - c0, 2);

        // R7: converter never finishes
        t0 = to_seen;
        eoc_dead = 1;
        pulse_start(4'b0011);
        wait_idle();
        chk(to_seen - t0 == 1, "R7", "timeout_pulses", to_seen - t0, 1);
        eoc_dead = 0;

        // R6: recovery after timeout with flag already high
        eoc_lat = 5;
        pulse_start(4'b1000);
        wait_idle();

        // R1: idle state holds
        repeat (10) @(negedge clk);
        chk(!busy_o && cs_n_o && convst_o, "R1", "idle_pins", {busy_o, cs_n_o, convst_o}, 3'b011);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule